// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Host Bus Port

This block is the digital half of a successive-approximation analog-to-digital converter. A host port made of an enable, an active-low select, a read/convert strobe, a width-format pin and one address bit does one of two things. It starts a conversion, or it drives the latest result onto a shared data bus. The sample-and-hold, the DAC, the comparator and the input scaling are outside the block. The block only drives the trial code for the DAC, reads back a single comparator decision, and produces the hold control, a conversion-clock enable and a busy flag.

A conversion can be full length (12 trials) or short (8 trials). It always runs to the end once it has started. After the last trial the sample-and-hold goes back to tracking, but busy stays high for a programmable acquisition interval. Reads are allowed during that interval. The result can be read as one 12-bit word or as two bytes placed on the upper eight bus lines.

Top module: `sar_adc_ctrl`

## Requirements
- R1: When `chip_en` is low or `chip_sel_n` is high, nothing happens whatever the other host pins are: no conversion starts and `bus_oe` stays low.
- R2: With `chip_en`=1, `chip_sel_n`=0 and `rd_conv`=0 at a clock edge while `busy` is low, a conversion starts. `addr0`=0 selects a 12-bit conversion and `addr0`=1 selects an 8-bit conversion.
- R3: After the start edge, `hold`, `clk_en` and `busy` are 1 and `dac_code` equals 0x800. The register has been cleared and only the MSB is set as its trial.
- R4: While `busy` is high, further start commands are ignored, so the length and the duration of the conversion do not change. While trials are running, a read gives `bus_oe`=0.
- R5: Trials go from bit 11 down, one bit per clock. The comparator input `cmp_above` is sampled at the edge after the trial bit appears on `dac_code`. The bit is cleared when `cmp_above`=1 and kept when it is 0. The next lower bit is set as the new trial at that same edge.
- R6: An 8-bit conversion stops after the trial of bit 4 and leaves result bits 3..0 at zero.
- R7: After the last decision, `hold` and `clk_en` fall, and `busy` stays high for ACQ_CYCLES more clocks. In total `busy` lasts N+ACQ_CYCLES clocks, where N is 12 or 8.
- R8: A read during the acquisition interval drives `bus_oe`=1 with valid result data.
- R9: A read is `chip_en`=1, `chip_sel_n`=0, `rd_conv`=1. With `fmt12`=1 the bus carries the whole 12-bit result, in the same cycle.
- R10: With `fmt12`=0 and `addr0`=0 the bus carries {result[11:4], 4'b0}. With `fmt12`=0 and `addr0`=1 it carries {result[3:0], 8'b0}.
- R11: Whenever `bus_oe` is low, `bus_data` is zero. After reset `busy`, `hold`, `clk_en` and `bus_oe` are 0 and `dac_code` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chip_en | input | 1 | Host enable, active high |
| chip_sel_n | input | 1 | Host select, active low |
| rd_conv | input | 1 | 1 = read, 0 = start conversion |
| fmt12 | input | 1 | Read format: 1 = 12-bit word, 0 = byte |
| addr0 | input | 1 | Conversion length on start, byte select on byte read |
| cmp_above | input | 1 | Comparator: 1 when DAC sum exceeds the held input |
| dac_code | output | 12 | Trial/result code to the DAC |
| hold | output | 1 | 1 = sample-and-hold in hold |
| clk_en | output | 1 | Conversion clock gate enable |
| busy | output | 1 | Conversion or acquisition in progress |
| bus_data | output | 12 | Read data, zero when not driven |
| bus_oe | output | 1 | Bus output enable |

## Verification
The start command acts at one rising edge. From the next cycle `hold`, `busy` and the MSB trial are visible. Each comparator decision takes effect at the edge after its trial bit is shown. Bus data and `bus_oe` follow the host pins in the same cycle, with no register in the path. The bench therefore drives every input on the falling edge. It samples registered outputs on the following falling edge, and it samples the bus a short delay after the pins change. It counts busy and hold cycles one falling edge at a time, so their lengths come out as exact counts (N+ACQ_CYCLES and N).

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRIAL = 2'd1,
    ST_ACQ   = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sar_host_decode.sv
module sar_host_decode (
  input  logic chip_en,
  input  logic chip_sel_n,
  input  logic rd_conv,
  output logic start_req,
  output logic read_req
);
  logic selected;

  always_comb begin
    selected  = chip_en && !chip_sel_n;
    start_req = selected && !rd_conv;
    read_req  = selected &&  rd_conv;
  end
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int WIDTH      = 12,
  parameter int SHORT_BITS = 8,
  parameter int ACQ_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             start_short,
  input  logic             cmp_above,
  output logic [WIDTH-1:0] sar_code,
  output logic             hold,
  output logic             clk_en,
  output logic             busy,
  output logic             converting
);
  localparam int IDXW       = $clog2(WIDTH);
  localparam int CNTW       = $clog2(ACQ_CYCLES + 1);
  localparam int SHORT_LAST = WIDTH - SHORT_BITS;

  sar_state_e       st_q, st_d;
  logic [WIDTH-1:0] sar_q, sar_d;
  logic [IDXW-1:0]  idx_q, idx_d, idx_nx, last_idx;
  logic             short_q, short_d;
  logic [CNTW-1:0]  cnt_q, cnt_d;

  assign last_idx = short_q ? IDXW'(SHORT_LAST) : '0;
  assign idx_nx   = idx_q - 1'b1;

  always_comb begin
    st_d    = st_q;
    sar_d   = sar_q;
    idx_d   = idx_q;
    short_d = short_q;
    cnt_d   = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (start_req) begin
          st_d             = ST_TRIAL;
          sar_d            = '0;
          sar_d[WIDTH-1]   = 1'b1;
          idx_d            = IDXW'(WIDTH - 1);
          short_d          = start_short;
        end
      end
      ST_TRIAL: begin
        if (cmp_above) sar_d[idx_q] = 1'b0;
        if (idx_q == last_idx) begin
          st_d  = ST_ACQ;
          cnt_d = CNTW'(ACQ_CYCLES - 1);
        end else begin
          idx_d         = idx_nx;
          sar_d[idx_nx] = 1'b1;
        end
      end
      ST_ACQ: begin
        if (cnt_q == '0) st_d = ST_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sar_q   <= '0;
      idx_q   <= '0;
      short_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      st_q    <= st_d;
      sar_q   <= sar_d;
      idx_q   <= idx_d;
      short_q <= short_d;
      cnt_q   <= cnt_d;
    end
  end

  assign sar_code   = sar_q;
  assign converting = (st_q == ST_TRIAL);
  assign hold       = converting;
  assign clk_en     = converting;
  assign busy       = (st_q != ST_IDLE);

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start_req) |=>
      (hold && clk_en && busy && sar_q == {1'b1, {(WIDTH-1){1'b0}}}));

  // R5
  trial_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRIAL && idx_q != last_idx) |=>
      (st_q == ST_TRIAL && idx_q == $past(idx_q) - 1'b1 && sar_q[idx_q]));

  // R4
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRIAL && start_req) |=> $stable(short_q));

  // R6
  short_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACQ && short_q) |-> (sar_q[SHORT_LAST-1:0] == '0));

  // R7
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRIAL && idx_q == last_idx) |=> (!hold && !clk_en && busy));

  // R7
  acq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> busy);
endmodule

// File: rtl/sar_bus_mux.sv
module sar_bus_mux #(
  parameter int WIDTH  = 12,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] result,
  input  logic             read_req,
  input  logic             converting,
  input  logic             fmt12,
  input  logic             addr0,
  output logic [WIDTH-1:0] bus_data,
  output logic             bus_oe
);
  localparam int LOW_W = WIDTH - BYTE_W;

  logic [WIDTH-1:0] hi_word, lo_word, sel_word;

  assign hi_word = {result[WIDTH-1 -: BYTE_W], {LOW_W{1'b0}}};
  assign lo_word = {result[LOW_W-1:0], {BYTE_W{1'b0}}};

  always_comb begin
    if (fmt12)      sel_word = result;
    else if (addr0) sel_word = lo_word;
    else            sel_word = hi_word;
    bus_oe   = read_req && !converting;
    bus_data = bus_oe ? sel_word : '0;
  end

  // R4
  oe_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !converting);

  // R11
  oe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_data == '0));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int WIDTH      = 12,
  parameter int SHORT_BITS = 8,
  parameter int ACQ_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             chip_sel_n,
  input  logic             rd_conv,
  input  logic             fmt12,
  input  logic             addr0,
  input  logic             cmp_above,
  output logic [WIDTH-1:0] dac_code,
  output logic             hold,
  output logic             clk_en,
  output logic             busy,
  output logic [WIDTH-1:0] bus_data,
  output logic             bus_oe
);
  logic rst_core_n;
  logic start_req, read_req, converting;

  sar_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  sar_host_decode u_dec (
    .chip_en    (chip_en),
    .chip_sel_n (chip_sel_n),
    .rd_conv    (rd_conv),
    .start_req  (start_req),
    .read_req   (read_req)
  );

  sar_engine #(
    .WIDTH      (WIDTH),
    .SHORT_BITS (SHORT_BITS),
    .ACQ_CYCLES (ACQ_CYCLES)
  ) u_eng (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start_req   (start_req),
    .start_short (addr0),
    .cmp_above   (cmp_above),
    .sar_code    (dac_code),
    .hold        (hold),
    .clk_en      (clk_en),
    .busy        (busy),
    .converting  (converting)
  );

  sar_bus_mux #(
    .WIDTH  (WIDTH),
    .BYTE_W (SHORT_BITS)
  ) u_bus (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .result     (dac_code),
    .read_req   (read_req),
    .converting (converting),
    .fmt12      (fmt12),
    .addr0      (addr0),
    .bus_data   (bus_data),
    .bus_oe     (bus_oe)
  );
endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
  localparam int ACQ = 4;

  logic clk = 0, rst_n = 0;
  logic chip_en = 0, chip_sel_n = 1, rd_conv = 0, fmt12 = 0, addr0 = 0;
  logic [11:0] vin_r = 0;
  logic cmp_above;
  logic [11:0] dac_code, bus_data;
  logic hold, clk_en, busy, bus_oe;
  int errors = 0, checks = 0, cycles = 0;

  always #5 clk = ~clk;
  assign cmp_above = (dac_code > vin_r);

  sar_adc_ctrl #(.ACQ_CYCLES(ACQ)) uut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
    .rd_conv(rd_conv), .fmt12(fmt12), .addr0(addr0), .cmp_above(cmp_above),
    .dac_code(dac_code), .hold(hold), .clk_en(clk_en), .busy(busy),
    .bus_data(bus_data), .bus_oe(bus_oe));

  // {short, vin, expected}
  localparam logic [24:0] VECS [6] = '{
    {1'b0, 12'hABC, 12'hABC}, {1'b0, 12'h000, 12'h000},
    {1'b0, 12'hFFF, 12'hFFF}, {1'b1, 12'h5A7, 12'h5A0},
    {1'b1, 12'hFFF, 12'hFF0}, {1'b0, 12'h801, 12'h801}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=50000", cycles);
      finish_run();
    end
  end

  task automatic idle_pins();
    chip_en = 0; chip_sel_n = 1; rd_conv = 0; fmt12 = 0; addr0 = 0;
  endtask

  task automatic do_read(input logic f12, input logic a0, output logic oe, output logic [11:0] d);
    chip_en = 1; chip_sel_n = 0; rd_conv = 1; fmt12 = f12; addr0 = a0;
    #1; oe = bus_oe; d = bus_data;
    idle_pins();
    #1;
  endtask

  // Starts a conversion; counts busy and hold cycles; optional restart poke.
  task automatic run_conv(input logic shrt, input logic [11:0] vin, input bit poke,
                          output int nbusy, output int nhold, output logic acq_oe,
                          output logic [11:0] acq_d);
    logic oe; logic [11:0] d;
    bit acq_done = 0;
    vin_r = vin;
    @(negedge clk);
    chip_en = 1; chip_sel_n = 0; rd_conv = 0; addr0 = shrt;
    @(posedge clk); @(negedge clk);
    idle_pins();
    nbusy = 0; nhold = 0; acq_oe = 0; acq_d = 0;
    for (int k = 0; k < 100 && busy; k++) begin
      nbusy++;
      if (hold) nhold++;
      if (poke && k == 3) begin
        chip_en = 1; chip_sel_n = 0; rd_conv = 0; addr0 = ~shrt;
      end
      if (poke && k == 5) begin
        do_read(1'b1, 1'b0, oe, d);
        chk("R4 read while converting oe", oe, 0);
      end
      if (!hold && !acq_done) begin
        acq_done = 1;
        do_read(1'b1, 1'b0, acq_oe, acq_d);
      end
      @(posedge clk); @(negedge clk);
      if (poke && k == 3) idle_pins();
    end
  endtask

  initial begin
    int nb, nh;
    logic aoe, oe;
    logic [11:0] ad, d, exp;
    idle_pins();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 reset busy", busy, 0);
    chk("R11 reset hold", hold, 0);
    chk("R11 reset clk_en", clk_en, 0);
    chk("R11 reset dac_code", dac_code, 0);
    chk("R11 reset bus_data", bus_data, 0);

    // Vector table walk
    foreach (VECS[i]) begin
      exp = VECS[i][11:0];
      run_conv(VECS[i][24], VECS[i][23:12], 0, nb, nh, aoe, ad);
      chk("R7 busy length", nb, (VECS[i][24] ? 8 : 12) + ACQ);
      chk("R5 R6 hold length", nh, VECS[i][24] ? 8 : 12);
      chk("R8 read in acquisition oe", aoe, 1);
      chk("R8 read in acquisition data", ad, exp);
      @(negedge clk);
      do_read(1'b1, 1'b0, oe, d);
      chk("R9 12-bit read", d, exp);
      chk("R9 12-bit read oe", oe, 1);
      do_read(1'b0, 1'b0, oe, d);
      chk("R10 high byte", d, {exp[11:4], 4'h0});
      do_read(1'b0, 1'b1, oe, d);
      chk("R10 low nibble", d, {exp[3:0], 8'h00});
      if (VECS[i][24]) chk("R6 short low bits", exp[3:0], 0);
    end

    // R3 start state and R5 first decision (vin = 0 clears MSB)
    vin_r = 12'h000;
    @(negedge clk);
    chip_en = 1; chip_sel_n = 0; rd_conv = 0; addr0 = 0;
    @(posedge clk); @(negedge clk);
    idle_pins();
    chk("R3 hold after start", hold, 1);
    chk("R3 clk_en after start", clk_en, 1);
    chk("R3 busy after start", busy, 1);
    chk("R3 MSB trial", dac_code, 12'h800);
    @(posedge clk); @(negedge clk);
    chk("R5 MSB cleared next trial", dac_code, 12'h400);
    vin_r = 12'hFFF;
    @(posedge clk); @(negedge clk);
    chk("R5 bit kept next trial", dac_code, 12'h600);
    while (busy) @(negedge clk);

    // R2 length via addr0 and R4 restart ignored (12-bit with short poke)
    run_conv(1'b0, 12'h3C5, 1, nb, nh, aoe, ad);
    chk("R4 restart ignored busy length", nb, 12 + ACQ);
    chk("R4 restart ignored result", ad, 12'h3C5);
    run_conv(1'b1, 12'h3C5, 1, nb, nh, aoe, ad);
    chk("R2 short conversion length", nh, 8);
    chk("R2 short result", ad, 12'h3C0);

    // R1 no-op cases
    @(negedge clk);
    chip_en = 0; chip_sel_n = 0; rd_conv = 0;
    @(posedge clk); @(negedge clk);
    chk("R1 chip_en low no start", busy, 0);
    chip_en = 1; chip_sel_n = 1; rd_conv = 0;
    @(posedge clk); @(negedge clk);
    chk("R1 select high no start", busy, 0);
    chip_en = 0; chip_sel_n = 0; rd_conv = 1; fmt12 = 1;
    #1;
    chk("R1 read disabled oe", bus_oe, 0);
    chk("R11 bus zero when not driven", bus_data, 0);
    idle_pins();
    chk("R1 result untouched", dac_code, 12'h3C0);

    finish_run();
  end
endmodule